// File: doc/BRIEF.md
# Register-Mapped GPIO Port Bank

This block holds three 8-bit general-purpose I/O ports behind a byte-addressed register bus. Software writes a port's data register to set the values that its pins should drive. It writes one of two mode registers to choose which pins are inputs and which are outputs. A read of a data register returns a mix, bit by bit: for an input bit it returns the synchronized pin, and for an output bit it returns the stored output value.

The three ports differ in how finely direction is set. Port A switches direction per 4-bit nibble, port B switches all eight bits together, and port C switches each bit on its own. Port C can also run in open-drain mode: a 1 releases the pin and a 0 pulls it low. Each bit keeps a separate output register, so software can preload a value before it turns the pin into an output. Pin inputs are asynchronous and pass through a two-flop synchronizer before any read sees them.

Register map: port A data at 00h, port B data at 01h, port C data at 02h, an unpopulated data slot at 03h, the shared mode register at F8h, and the port C direction register at F6h. Writes take effect on the rising clock edge. Read data is combinational from the registered state.

Top module: `gpio_bank`

## Requirements
- R1: After reset every output enable is 0, every output register is 0, F8h reads 07h (all directions input, open-drain off) and F6h reads FFh.
- R2: A write to 00h, 01h or 02h always loads that port's output register, whatever the bit directions are. In push-pull mode the value shows on the port's out pins on the next cycle, and it is driven once the bit becomes an output.
- R3: A read of a data register returns, for each bit, the synchronized pin value when the bit is an input and the output register value when the bit is an output.
- R4: A pin change is visible to reads after exactly two rising clock edges, and not after one.
- R5: In F8h, bit 0 set to 1 makes port A bits 3:0 inputs and bit 1 set to 1 makes port A bits 7:4 inputs. Each nibble's output enables are always all equal.
- R6: F8h bit 2 set to 1 makes all of port B input and 0 makes all of port B output. Port B output enables are always all 0 or all 1.
- R7: F6h bit n set to 1 makes port C bit n an input, and 0 makes it an output, independently for each n.
- R8: F8h bit 3 set to 1 selects open-drain for port C. Its out pins are then 0, and the enable of an output bit is set only where its output register holds 0. With bit 3 at 0, port C is push-pull like the other ports.
- R9: Reads of 03h and of any unmapped address return 00h. Writes to them change no pin output or output enable.
- R10: F8h reads back its four defined bits with bits 7:4 as zero, and F6h reads back all eight bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe for the register bus |
| bus_addr | input | 8 | Register byte address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Combinational read data |
| pa_in | input | 8 | Port A pin inputs (asynchronous) |
| pa_out | output | 8 | Port A pin output values |
| pa_oe | output | 8 | Port A output enables |
| pb_in | input | 8 | Port B pin inputs (asynchronous) |
| pb_out | output | 8 | Port B pin output values |
| pb_oe | output | 8 | Port B output enables |
| pc_in | input | 8 | Port C pin inputs (asynchronous) |
| pc_out | output | 8 | Port C pin output values |
| pc_oe | output | 8 | Port C output enables |

## Verification
The bench builds the bank with its default parameters: 8-bit ports and two synchronizer stages. With these values the one-edge and two-edge read latencies can be told apart at the ports. Each nibble of port A can be set in the opposite direction to the other, giving mixed reads. Port C can hold a pattern of input and output bits while open-drain is switched on and off, so the released, pulled-low and read-back behaviour can all be seen on the same bits.

// File: rtl/gpio_pkg.sv
package gpio_pkg;

    localparam int PORT_W      = 8;
    localparam int SYNC_DEPTH  = 2;

    typedef logic [7:0] addr_t;

    localparam addr_t ADDR_PA   = 8'h00;
    localparam addr_t ADDR_PB   = 8'h01;
    localparam addr_t ADDR_PC   = 8'h02;
    localparam addr_t ADDR_PD   = 8'h03;
    localparam addr_t ADDR_MODE = 8'hF8;
    localparam addr_t ADDR_PCDIR= 8'hF6;

    // Shared mode register: the packed order fixes bit positions 3..0.
    typedef struct packed {
        logic pc_odrain;
        logic pb_input;
        logic pa_hi_input;
        logic pa_lo_input;
    } mode_reg_t;

    localparam mode_reg_t MODE_RESET = '{pc_odrain: 1'b0, pb_input: 1'b1,
                                         pa_hi_input: 1'b1, pa_lo_input: 1'b1};

endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
    parameter int W      = 8,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_in,
    output logic [W-1:0] sync_out
);

    logic [W-1:0] chain_q [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (!rst_n) chain_q[s] <= '0;
                    else        chain_q[s] <= async_in;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (!rst_n) chain_q[s] <= '0;
                    else        chain_q[s] <= chain_q[s-1];
                end
            end
        end
    endgenerate

    assign sync_out = chain_q[STAGES-1];

endmodule

// File: rtl/gpio_mode_regs.sv
module gpio_mode_regs
    import gpio_pkg::*;
#(
    parameter int W = 8
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  addr_t       addr,
    input  logic [W-1:0] wdata,
    output mode_reg_t   mode_q,
    output logic [W-1:0] pc_dir_q
);

    localparam int MODE_W = $bits(mode_reg_t);

    logic hit_mode;
    logic hit_pcdir;

    assign hit_mode  = wr_en && (addr == ADDR_MODE);
    assign hit_pcdir = wr_en && (addr == ADDR_PCDIR);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= MODE_RESET;
        end else if (hit_mode) begin
            mode_q <= mode_reg_t'(wdata[MODE_W-1:0]);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc_dir_q <= '1;
        end else if (hit_pcdir) begin
            pc_dir_q <= wdata;
        end
    end

endmodule

// File: rtl/gpio_port.sv
module gpio_port #(
    parameter int W          = 8,
    parameter int GROUP      = 8,
    parameter bit OD_CAPABLE = 1'b0,
    parameter int SYNC_DEPTH = 2,
    localparam int NGRP      = W / GROUP
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic [W-1:0]    wdata,
    input  logic [NGRP-1:0] grp_is_input,
    input  logic            od_req,
    input  logic [W-1:0]    pin_in,
    output logic [W-1:0]    pin_out,
    output logic [W-1:0]    pin_oe,
    output logic [W-1:0]    rd_val
);

    logic [W-1:0] out_q;
    logic [W-1:0] sync_val;
    logic [W-1:0] bit_is_input;
    logic         od_eff;

    // Expand one direction control per group to one per bit.
    generate
        for (genvar i = 0; i < W; i++) begin : g_dir
            assign bit_is_input[i] = grp_is_input[i / GROUP];
        end
    endgenerate

    assign od_eff = OD_CAPABLE ? od_req : 1'b0;

    always_ff @(posedge clk) begin
        if (!rst_n)     out_q <= '0;
        else if (wr_en) out_q <= wdata;
    end

    gpio_sync #(.W(W), .STAGES(SYNC_DEPTH)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (pin_in),
        .sync_out (sync_val)
    );

    always_comb begin
        if (od_eff) begin
            pin_out = '0;
            pin_oe  = ~bit_is_input & ~out_q;
        end else begin
            pin_out = out_q;
            pin_oe  = ~bit_is_input;
        end
    end

    assign rd_val = (bit_is_input & sync_val) | (~bit_is_input & out_q);

endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
    import gpio_pkg::*;
#(
    parameter int W     = PORT_W,
    parameter int SYNCS = SYNC_DEPTH
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         bus_wr,
    input  logic [7:0]   bus_addr,
    input  logic [W-1:0] bus_wdata,
    output logic [W-1:0] bus_rdata,
    input  logic [W-1:0] pa_in,
    output logic [W-1:0] pa_out,
    output logic [W-1:0] pa_oe,
    input  logic [W-1:0] pb_in,
    output logic [W-1:0] pb_out,
    output logic [W-1:0] pb_oe,
    input  logic [W-1:0] pc_in,
    output logic [W-1:0] pc_out,
    output logic [W-1:0] pc_oe
);

    localparam int MODE_W = $bits(mode_reg_t);
    localparam int HALF   = W / 2;

    mode_reg_t    mode_q;
    logic [W-1:0] pc_dir_q;
    logic [W-1:0] pa_rd, pb_rd, pc_rd;
    logic         od_on;

    assign od_on = mode_q.pc_odrain;

    gpio_mode_regs #(.W(W)) u_mode (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (bus_wr),
        .addr     (bus_addr),
        .wdata    (bus_wdata),
        .mode_q   (mode_q),
        .pc_dir_q (pc_dir_q)
    );

    gpio_port #(.W(W), .GROUP(HALF), .OD_CAPABLE(1'b0), .SYNC_DEPTH(SYNCS)) u_pa (
        .clk          (clk),
        .rst_n        (rst_n),
        .wr_en        (bus_wr && (bus_addr == ADDR_PA)),
        .wdata        (bus_wdata),
        .grp_is_input ({mode_q.pa_hi_input, mode_q.pa_lo_input}),
        .od_req       (1'b0),
        .pin_in       (pa_in),
        .pin_out      (pa_out),
        .pin_oe       (pa_oe),
        .rd_val       (pa_rd)
    );

    gpio_port #(.W(W), .GROUP(W), .OD_CAPABLE(1'b0), .SYNC_DEPTH(SYNCS)) u_pb (
        .clk          (clk),
        .rst_n        (rst_n),
        .wr_en        (bus_wr && (bus_addr == ADDR_PB)),
        .wdata        (bus_wdata),
        .grp_is_input (mode_q.pb_input),
        .od_req       (1'b0),
        .pin_in       (pb_in),
        .pin_out      (pb_out),
        .pin_oe       (pb_oe),
        .rd_val       (pb_rd)
    );

    gpio_port #(.W(W), .GROUP(1), .OD_CAPABLE(1'b1), .SYNC_DEPTH(SYNCS)) u_pc (
        .clk          (clk),
        .rst_n        (rst_n),
        .wr_en        (bus_wr && (bus_addr == ADDR_PC)),
        .wdata        (bus_wdata),
        .grp_is_input (pc_dir_q),
        .od_req       (od_on),
        .pin_in       (pc_in),
        .pin_out      (pc_out),
        .pin_oe       (pc_oe),
        .rd_val       (pc_rd)
    );

    always_comb begin
        unique case (bus_addr)
            ADDR_PA:    bus_rdata = pa_rd;
            ADDR_PB:    bus_rdata = pb_rd;
            ADDR_PC:    bus_rdata = pc_rd;
            ADDR_MODE:  bus_rdata = {{(W-MODE_W){1'b0}}, mode_q};
            ADDR_PCDIR: bus_rdata = pc_dir_q;
            default:    bus_rdata = '0;
        endcase
    end

endmodule

// File: rtl/gpio_bank_chk.sv
module gpio_bank_chk #(
    parameter int W = 8
) (
    input logic         clk,
    input logic         rst_n,
    input logic         bus_wr,
    input logic [7:0]   bus_addr,
    input logic [W-1:0] bus_wdata,
    input logic [W-1:0] bus_rdata,
    input logic [W-1:0] pa_out,
    input logic [W-1:0] pa_oe,
    input logic [W-1:0] pb_out,
    input logic [W-1:0] pb_oe,
    input logic [W-1:0] pc_out,
    input logic [W-1:0] pc_oe,
    input logic         od_mode
);

    localparam int HALF = W / 2;

    p_reset_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (pa_oe == '0 && pb_oe == '0 && pc_oe == '0 &&
                          pa_out == '0 && pb_out == '0 && pc_out == '0));

    p_write_pa_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == 8'h00) |=> pa_out == $past(bus_wdata));

    p_write_pb_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == 8'h01) |=> pb_out == $past(bus_wdata));

    p_nibble_uniform_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ((pa_oe[HALF-1:0] == '0 || pa_oe[HALF-1:0] == '1) &&
         (pa_oe[W-1:HALF] == '0 || pa_oe[W-1:HALF] == '1)));

    p_pa_dir_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_wr && bus_addr == 8'hF8) |=> $stable(pa_oe));

    p_byte_uniform_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (pb_oe == '0 || pb_oe == '1));

    p_pc_dir_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_wr && (bus_addr == 8'hF8 || bus_addr == 8'hF6 || bus_addr == 8'h02))
        |=> $stable(pc_oe));

    p_odrain_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
        od_mode |-> pc_out == '0);

    p_unmapped_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == 8'h03) |-> bus_rdata == '0);

    p_mode_upper_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == 8'hF8) |-> bus_rdata[W-1:HALF] == '0);

endmodule

bind gpio_bank gpio_bank_chk #(.W(W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .pa_out    (pa_out),
    .pa_oe     (pa_oe),
    .pb_out    (pb_out),
    .pb_oe     (pb_oe),
    .pc_out    (pc_out),
    .pc_oe     (pc_oe),
    .od_mode   (od_on)
);

// File: tb/sim_gpio_bank.sv
`timescale 1ns/1ps
module sim_gpio_bank;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_wr = 1'b0;
    logic [7:0] bus_addr = 8'h00;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic [7:0] pa_in = 8'h00, pb_in = 8'h00, pc_in = 8'h00;
    logic [7:0] pa_out, pa_oe, pb_out, pb_oe, pc_out, pc_oe;

    int total = 0;
    int bad   = 0;

    always #2 clk = ~clk;

    gpio_bank u0 (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pa_in(pa_in), .pa_out(pa_out), .pa_oe(pa_oe),
        .pb_in(pb_in), .pb_out(pb_out), .pb_oe(pb_oe),
        .pc_in(pc_in), .pc_out(pc_out), .pc_oe(pc_oe)
    );

    task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s: got %02h expected %02h", tag, got, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [7:0] d);
        bus_addr = a;
        #0.5;
        d = bus_rdata;
    endtask

    task automatic settle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic t_reset;
        logic [7:0] v;
        chk("R1 pa_oe", pa_oe, 8'h00);
        chk("R1 pb_oe", pb_oe, 8'h00);
        chk("R1 pc_oe", pc_oe, 8'h00);
        chk("R1 pc_out", pc_out, 8'h00);
        rd(8'hF8, v); chk("R1 mode reset", v, 8'h07);
        rd(8'hF6, v); chk("R1 pc dir reset", v, 8'hFF);
    endtask

    task automatic t_prewrite_nibble;
        logic [7:0] v;
        pa_in = 8'h3C;
        wr(8'h00, 8'hA5);
        chk("R2 pa_out preload", pa_out, 8'hA5);
        chk("R2 pa_oe still off", pa_oe, 8'h00);
        settle(2);
        rd(8'h00, v); chk("R3 input read", v, 8'h3C);
        wr(8'hF8, 8'h06);
        chk("R5 low nibble out", pa_oe, 8'h0F);
        rd(8'h00, v); chk("R5 mixed read", v, 8'h35);
        wr(8'hF8, 8'h05);
        chk("R5 high nibble out", pa_oe, 8'hF0);
        rd(8'h00, v); chk("R5 mixed read hi", v, 8'hAC);
        wr(8'hF8, 8'h04);
        chk("R5 both nibbles out", pa_oe, 8'hFF);
        rd(8'h00, v); chk("R3 output read", v, 8'hA5);
    endtask

    task automatic t_sync;
        logic [7:0] v;
        @(negedge clk);
        pb_in = 8'h5A;
        @(negedge clk);
        rd(8'h01, v); chk("R4 one edge old", v, 8'h00);
        @(negedge clk);
        rd(8'h01, v); chk("R4 two edges new", v, 8'h5A);
    endtask

    task automatic t_byte;
        logic [7:0] v;
        wr(8'h01, 8'hC3);
        rd(8'h01, v); chk("R6 input still", v, 8'h5A);
        wr(8'hF8, 8'h00);
        chk("R6 all out", pb_oe, 8'hFF);
        chk("R6 pb_out", pb_out, 8'hC3);
        rd(8'h01, v); chk("R6 read out", v, 8'hC3);
    endtask

    task automatic t_perbit;
        logic [7:0] v;
        pc_in = 8'hAA;
        wr(8'h02, 8'hF0);
        wr(8'hF6, 8'h0F);
        chk("R7 pc_oe", pc_oe, 8'hF0);
        chk("R7 pc_out", pc_out, 8'hF0);
        rd(8'h02, v); chk("R7 mixed read", v, 8'hFA);
        wr(8'hF6, 8'h5A);
        chk("R7 scattered oe", pc_oe, 8'hA5);
        wr(8'hF6, 8'h0F);
    endtask

    task automatic t_odrain;
        logic [7:0] v;
        wr(8'hF8, 8'h08);
        chk("R8 od out low", pc_out, 8'h00);
        chk("R8 od ones released", pc_oe, 8'h00);
        wr(8'h02, 8'h30);
        chk("R8 od zeros pulled", pc_oe, 8'hC0);
        rd(8'h02, v); chk("R8 od read", v, 8'h3A);
        wr(8'hF8, 8'h00);
        chk("R8 back push-pull out", pc_out, 8'h30);
        chk("R8 back push-pull oe", pc_oe, 8'hF0);
    endtask

    task automatic t_unmapped;
        logic [7:0] v;
        wr(8'h03, 8'hFF);
        wr(8'h40, 8'h00);
        chk("R9 pa_out kept", pa_out, 8'hA5);
        chk("R9 pb_out kept", pb_out, 8'hC3);
        chk("R9 pc_out kept", pc_out, 8'h30);
        chk("R9 pa_oe kept", pa_oe, 8'hFF);
        rd(8'h03, v); chk("R9 slot 03 zero", v, 8'h00);
        rd(8'h40, v); chk("R9 unmapped zero", v, 8'h00);
    endtask

    task automatic t_readback;
        logic [7:0] v;
        wr(8'hF8, 8'hFF);
        rd(8'hF8, v); chk("R10 mode readback", v, 8'h0F);
        rd(8'hF6, v); chk("R10 dir readback", v, 8'h0F);
        wr(8'hF6, 8'hC6);
        rd(8'hF6, v); chk("R10 dir readback 2", v, 8'hC6);
    endtask

    initial begin
        #(4 * 150000);
        total++; bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        settle(3);
        rst_n = 1'b1;
        settle(1);
        t_reset;
        t_prewrite_nibble;
        t_sync;
        t_byte;
        t_perbit;
        t_odrain;
        t_unmapped;
        t_readback;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule